// File: doc/BRIEF.md
# Wide-Fetch Alignment and Pointer Update Unit

This unit sits between a display fetch engine and its memory port. It reads 16, 32 or 64 bits per access. A 2-bit fetch-size selector sets the width. From the current plane pointer the unit forms the aligned memory address. It takes the raw word that memory returns and emits the fetched word. When the pointer is not a multiple of the access size, the unit does not fault and does not rotate the data. It copies half-words inside the fetched word instead.

After each accepted fetch the pointer moves on by the access size. At the end of a line a signed modulo can be added to the pointer. That addition drops the carry out of the low address bits that the access size covers.

Raw data enters on a valid/ready stream and the fetched word leaves on another. The output stage holds one entry. `in_ready` is high when that entry is empty or is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the output word is held unchanged and no new raw word is accepted. Pointer load, modulo add and the fetch-size selector are plain control inputs.

Top module: `wfa_fetch_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `ptr_o` is 0.
- R2: `mem_addr` is the pointer with its low bits cleared: bit 0 for size code 0, bits 1..0 for codes 1 and 2, and bits 2..0 for code 3.
- R3: For size code 0, bits 15..0 of the output word are `in_raw[15:0]` and all upper bits are zero.
- R4: For size code 1, bits 31..0 of the output are `in_raw[31:0]`, except that when the pointer's bits 1..0 are nonzero, output bits 31..16 take `in_raw[15:0]`. Bits 63..32 are zero.
- R5: For size code 2, the output behaves as for code 1 when the pointer's bits 1..0 are nonzero. When those bits are zero, output bits 15..0 take `in_raw[31:16]`. Bits 63..32 are zero.
- R6: For size code 3, the whole 64-bit raw word is used. If the pointer's bits 2..0 are nonzero, bits 31..0 are first copied into bits 63..32. Then, if the pointer's bits 1..0 are nonzero, each 32-bit half has its low 16 bits copied into its upper 16 bits.
- R7: Each accepted fetch advances the pointer by 2, 4, 4 or 8 bytes for size codes 0 to 3. The pointer wraps modulo 2^21.
- R8: A modulo add sign-extends `mod_val`. For codes 1 and 2 it sums bits 1..0 modulo 4 and discards their carry, and for code 3 it does the same over bits 2..0 modulo 8. The remaining upper bits add normally. For example, 0x10002 plus 6 under code 1 gives 0x10004.
- R9: Under size code 0, a modulo add is a plain two's-complement addition.
- R10: `ptr_load` sets the pointer to `ptr_load_val` on the next edge. It takes priority over a fetch advance and over a modulo add in the same cycle. A fetch accepted in that cycle still produces its output word from the old pointer.
- R11: When a fetch and a modulo add occur in the same cycle, the pointer first advances by the fetch size. The modulo is then added to the advanced value, with the carry rule of R8.
- R12: An accepted raw word gives `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, `out_data` stays stable and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_mode | input | 2 | Access size code: 0=16, 1=32, 2=32 with low-half fill, 3=64 bits |
| ptr_load | input | 1 | Load the pointer from `ptr_load_val` |
| ptr_load_val | input | 21 | New pointer value |
| mod_add | input | 1 | Add the line modulo to the pointer |
| mod_val | input | 16 | Signed line modulo in bytes |
| mem_addr | output | 21 | Aligned memory byte address for the current pointer |
| in_valid | input | 1 | Raw memory word valid |
| in_ready | output | 1 | Unit can accept a raw word |
| in_raw | input | 64 | Raw word read from `mem_addr` (narrow sizes in the low bits) |
| out_valid | output | 1 | Fetched word valid |
| out_ready | input | 1 | Consumer takes the fetched word |
| out_data | output | 64 | Fetched word after alignment fill |
| ptr_o | output | 21 | Current pointer |

## Verification
The bench builds the unit with its default parameters: a 16-bit base word, a 21-bit pointer and a 16-bit modulo. With these values the top of the pointer range can be reached, so a 64-bit advance is seen to wrap past 0x1FFFFF. A negative modulo exercises the sign extension. The 64-bit word leaves room for every alignment case of each size code: 8-byte aligned, 4-byte aligned only, 2-byte offset, and 6-byte offset.

// File: rtl/wfa_pkg.sv
package wfa_pkg;
  typedef enum logic [1:0] {
    FM_W16  = 2'd0,
    FM_W32  = 2'd1,
    FM_W32F = 2'd2,
    FM_W64  = 2'd3
  } fmode_e;
endpackage

// File: rtl/wfa_addr_unit.sv
module wfa_addr_unit
  import wfa_pkg::*;
#(
  parameter int PTR_W = 21
) (
  input  fmode_e             mode,
  input  logic [PTR_W-1:0]   ptr,
  output logic [PTR_W-1:0]   aligned,
  output logic [PTR_W-1:0]   step,
  output logic [1:0]         lo_bits
);
  logic [PTR_W-1:0] mask;

  always_comb begin
    unique case (mode)
      FM_W16:  begin mask = PTR_W'(1); step = PTR_W'(2); lo_bits = 2'd0; end
      FM_W32,
      FM_W32F: begin mask = PTR_W'(3); step = PTR_W'(4); lo_bits = 2'd2; end
      default: begin mask = PTR_W'(7); step = PTR_W'(8); lo_bits = 2'd3; end
    endcase
    aligned = ptr & ~mask;
  end
endmodule

// File: rtl/wfa_dup.sv
module wfa_dup
  import wfa_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  fmode_e                 mode,
  input  logic [2:0]             addr_lo,
  input  logic [4*WORD_W-1:0]    raw,
  output logic [4*WORD_W-1:0]    data
);
  localparam int DW = 4 * WORD_W;
  localparam int HW = 2 * WORD_W;

  logic             unal4;
  logic             unal8;
  logic [DW-1:0]    wide_s1;
  logic [DW-1:0]    wide_s2;
  logic [HW-1:0]    pair;

  assign unal4 = (addr_lo[1:0] != 2'b00);
  assign unal8 = (addr_lo != 3'b000);

  always_comb begin
    wide_s1 = raw;
    if (unal8) wide_s1[DW-1:HW] = raw[HW-1:0];
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign wide_s2[h*HW +: HW] = unal4
      ? {wide_s1[h*HW +: WORD_W], wide_s1[h*HW +: WORD_W]}
      : wide_s1[h*HW +: HW];
  end

  always_comb begin
    data = '0;
    pair = raw[HW-1:0];
    unique case (mode)
      FM_W16: data[WORD_W-1:0] = raw[WORD_W-1:0];
      FM_W32: begin
        if (unal4) pair[HW-1:WORD_W] = raw[WORD_W-1:0];
        data[HW-1:0] = pair;
      end
      FM_W32F: begin
        if (unal4) pair[HW-1:WORD_W] = raw[WORD_W-1:0];
        else       pair[WORD_W-1:0]  = raw[HW-1:WORD_W];
        data[HW-1:0] = pair;
      end
      default: data = wide_s2;
    endcase
  end

  always_comb begin
    if (mode == FM_W16)
      AST_M0_UPPER_ZERO: assert (data[DW-1:WORD_W] == '0); // R3
    if (mode == FM_W32F)
      AST_M2_HALVES_EQ: assert (data[HW-1:WORD_W] == data[WORD_W-1:0]); // R5
    if (mode == FM_W64 && unal8)
      AST_M3_UNALIGNED_DUP: assert (data[DW-1:HW] == data[HW-1:0]); // R6
  end
endmodule

// File: rtl/wfa_mod_adder.sv
module wfa_mod_adder #(
  parameter int PTR_W = 21,
  parameter int MOD_W = 16
) (
  input  logic [PTR_W-1:0] base,
  input  logic [MOD_W-1:0] modv,
  input  logic [1:0]       lo_bits,
  output logic [PTR_W-1:0] sum
);
  logic [PTR_W-1:0] mod_ext;
  logic [PTR_W-1:0] lo_mask;
  logic [PTR_W-1:0] lo_sum;
  logic [PTR_W-1:0] hi_sum;

  assign mod_ext = PTR_W'($signed(modv));

  always_comb begin
    lo_mask = (PTR_W'(1) << lo_bits) - PTR_W'(1);
    lo_sum  = (base + mod_ext) & lo_mask;
    hi_sum  = (base & ~lo_mask) + (mod_ext & ~lo_mask);
    sum     = hi_sum | lo_sum;
  end
endmodule

// File: rtl/wfa_fetch_unit.sv
module wfa_fetch_unit
  import wfa_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int PTR_W  = 21,
  parameter int MOD_W  = 16,
  localparam int DW    = 4 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fetch_mode,
  input  logic              ptr_load,
  input  logic [PTR_W-1:0]  ptr_load_val,
  input  logic              mod_add,
  input  logic [MOD_W-1:0]  mod_val,
  output logic [PTR_W-1:0]  mem_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_raw,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic [PTR_W-1:0]  ptr_o
);
  fmode_e            mode;
  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  step;
  logic [1:0]        lo_bits;
  logic [PTR_W-1:0]  after_fetch;
  logic [PTR_W-1:0]  mod_sum;
  logic [PTR_W-1:0]  ptr_d;
  logic [DW-1:0]     fetched;
  logic              fire;

  assign mode     = fmode_e'(fetch_mode);
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign ptr_o    = ptr_q;

  wfa_addr_unit #(.PTR_W(PTR_W)) u_addr (
    .mode    (mode),
    .ptr     (ptr_q),
    .aligned (mem_addr),
    .step    (step),
    .lo_bits (lo_bits)
  );

  wfa_dup #(.WORD_W(WORD_W)) u_dup (
    .mode    (mode),
    .addr_lo (ptr_q[2:0]),
    .raw     (in_raw),
    .data    (fetched)
  );

  assign after_fetch = fire ? (ptr_q + step) : ptr_q;

  wfa_mod_adder #(.PTR_W(PTR_W), .MOD_W(MOD_W)) u_mod (
    .base    (after_fetch),
    .modv    (mod_val),
    .lo_bits (lo_bits),
    .sum     (mod_sum)
  );

  always_comb begin
    if (ptr_load)     ptr_d = ptr_load_val;
    else if (mod_add) ptr_d = mod_sum;
    else              ptr_d = after_fetch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      ptr_q <= ptr_d;
      if (fire) begin
        out_valid <= 1'b1;
        out_data  <= fetched;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R12
  AST_FIRE_GIVES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R12
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> ptr_o == $past(ptr_load_val)); // R10
endmodule

// File: tb/wfa_fetch_unit_tb_top.sv
`timescale 1ns/1ps
module wfa_fetch_unit_tb_top;
  localparam int PW = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    fetch_mode = 2'd0;
  logic          ptr_load = 1'b0;
  logic [PW-1:0] ptr_load_val = '0;
  logic          mod_add = 1'b0;
  logic [15:0]   mod_val = '0;
  logic [PW-1:0] mem_addr;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [63:0]   in_raw = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [63:0]   out_data;
  logic [PW-1:0] ptr_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] exp_q[$];
  logic [PW-1:0] pm = '0;

  always #2.5 clk = ~clk;

  wfa_fetch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_mode(fetch_mode),
    .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
    .mod_add(mod_add), .mod_val(mod_val), .mem_addr(mem_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_raw(in_raw),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .ptr_o(ptr_o)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_data(logic [1:0] m, logic [PW-1:0] p, logic [63:0] r);
    logic [15:0] w0, w1, w2, w3, u0, u1;
    logic a4, a8;
    w0 = r[15:0]; w1 = r[31:16]; w2 = r[47:32]; w3 = r[63:48];
    a4 = (p % 4) != 0;
    a8 = (p % 8) != 0;
    case (m)
      2'd0: return {48'h0, w0};
      2'd1: return {32'h0, (a4 ? w0 : w1), w0};
      2'd2: return a4 ? {32'h0, w0, w0} : {32'h0, w1, w1};
      default: begin
        u0 = a8 ? w0 : w2;
        u1 = a8 ? w1 : w3;
        if (a4) return {u0, u0, w0, w0};
        return {u1, u0, w1, w0};
      end
    endcase
  endfunction

  function automatic logic [PW-1:0] exp_mod(logic [1:0] m, logic [PW-1:0] p, logic [15:0] mv);
    int unsigned k, lo, hi, pm_i, mv_i;
    k = (m == 2'd0) ? 0 : (m == 2'd3) ? 3 : 2;
    pm_i = p;
    mv_i = {{(32-16){mv[15]}}, mv};
    lo = ((pm_i % (1 << k)) + (mv_i % (1 << k))) % (1 << k);
    hi = ((pm_i >> k) + (mv_i >> k)) << k;
    return PW'(hi + lo);
  endfunction

  function automatic logic [PW-1:0] step_of(logic [1:0] m);
    return (m == 2'd0) ? PW'(2) : (m == 2'd3) ? PW'(8) : PW'(4);
  endfunction

  // driver: one cycle of stimulus; pushes expected output and updates pointer model
  task automatic do_op(logic [1:0] m, logic f, logic [63:0] r,
                       logic ma, logic [15:0] mv, logic ld, logic [PW-1:0] lv);
    logic acc;
    logic [PW-1:0] nxt;
    @(negedge clk);
    fetch_mode = m; in_valid = f; in_raw = r;
    mod_add = ma; mod_val = mv; ptr_load = ld; ptr_load_val = lv;
    #1;
    acc = f && in_ready;
    nxt = pm;
    if (acc) begin
      exp_q.push_back(exp_data(m, pm, r));
      nxt = pm + step_of(m);
    end
    if (ma) nxt = exp_mod(m, nxt, mv);
    if (ld) nxt = lv;
    pm = nxt;
    @(negedge clk);
    in_valid = 1'b0; mod_add = 1'b0; ptr_load = 1'b0;
    #1;
  endtask

  task automatic chk_ptr(string tag);
    chk(tag, 64'(ptr_o), 64'(pm));
  endtask

  // monitor: compares produced words against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) chk("R12 unexpected output", out_data, 64'hx);
        else chk("R3-R6 data", out_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  localparam logic [63:0] RAW = 64'hDDDD_CCCC_BBBB_AAAA;

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 in_ready", 64'(in_ready), 64'd1);
    chk("R1 ptr", 64'(ptr_o), 64'd0);
    @(negedge clk); rst_n = 1'b1; #1;

    // R10 load, R2 address, R8 worked example
    do_op(2'd1, 0, 0, 0, 0, 1, 21'h10002);
    chk_ptr("R10 load");
    chk("R2 addr mode1", 64'(mem_addr), 64'h10000);
    do_op(2'd1, 0, 0, 1, 16'd6, 0, 0);
    chk("R8 example", 64'(ptr_o), 64'h10004);

    // R3 mode 0 and R2 / R7
    do_op(2'd0, 0, 0, 0, 0, 1, 21'h00101);
    chk("R2 addr mode0", 64'(mem_addr), 64'h100);
    do_op(2'd0, 1, RAW, 0, 0, 0, 0);
    chk_ptr("R7 step mode0");

    // R4 mode 1 aligned then unaligned
    do_op(2'd1, 0, 0, 0, 0, 1, 21'h200);
    do_op(2'd1, 1, RAW, 0, 0, 0, 0);
    chk_ptr("R7 step mode1");
    do_op(2'd1, 0, 0, 0, 0, 1, 21'h202);
    do_op(2'd1, 1, RAW, 0, 0, 0, 0);

    // R5 mode 2 both ways
    do_op(2'd2, 0, 0, 0, 0, 1, 21'h300);
    do_op(2'd2, 1, RAW, 0, 0, 0, 0);
    chk_ptr("R7 step mode2");
    do_op(2'd2, 1, RAW, 0, 0, 0, 0);
    do_op(2'd2, 0, 0, 0, 0, 1, 21'h301);
    do_op(2'd2, 1, RAW, 0, 0, 0, 0);

    // R6 mode 3 all alignments
    do_op(2'd3, 0, 0, 0, 0, 1, 21'h406);
    chk("R2 addr mode3", 64'(mem_addr), 64'h400);
    do_op(2'd3, 1, RAW, 0, 0, 0, 0);
    chk_ptr("R7 step mode3");
    do_op(2'd3, 0, 0, 0, 0, 1, 21'h400);
    do_op(2'd3, 1, RAW, 0, 0, 0, 0);
    do_op(2'd3, 0, 0, 0, 0, 1, 21'h404);
    do_op(2'd3, 1, RAW, 0, 0, 0, 0);
    do_op(2'd3, 0, 0, 0, 0, 1, 21'h402);
    do_op(2'd3, 1, RAW, 0, 0, 0, 0);

    // R7 wrap
    do_op(2'd3, 0, 0, 0, 0, 1, 21'h1FFFFE);
    do_op(2'd3, 1, RAW, 0, 0, 0, 0);
    chk("R7 wrap", 64'(ptr_o), 64'h6);

    // R8 mode 3 carry drop, R9 mode 0 negative modulo
    do_op(2'd3, 0, 0, 0, 0, 1, 21'h1005);
    do_op(2'd3, 0, 0, 1, 16'd5, 0, 0);
    chk("R8 mode3", 64'(ptr_o), 64'h1002);
    do_op(2'd0, 0, 0, 0, 0, 1, 21'h1000);
    do_op(2'd0, 0, 0, 1, 16'hFFFC, 0, 0);
    chk("R9 mode0 neg", 64'(ptr_o), 64'hFFC);

    // R11 fetch and modulo together
    do_op(2'd2, 0, 0, 0, 0, 1, 21'h302);
    do_op(2'd2, 1, RAW, 1, 16'd2, 0, 0);
    chk("R11 fetch+mod", 64'(ptr_o), 64'h304);

    // R10 load beats fetch and modulo
    do_op(2'd1, 1, 64'h1234_5678_9ABC_DEF0, 1, 16'd8, 1, 21'h0ABCD);
    chk("R10 load priority", 64'(ptr_o), 64'h0ABCD);

    // R12 back-pressure
    @(negedge clk); out_ready = 1'b0;
    do_op(2'd1, 0, 0, 0, 0, 1, 21'h500);
    do_op(2'd1, 1, 64'h0000_0000_5555_6666, 0, 0, 0, 0);
    chk("R12 valid", 64'(out_valid), 64'd1);
    chk("R12 in_ready low", 64'(in_ready), 64'd0);
    held = out_data;
    do_op(2'd1, 1, 64'h0000_0000_7777_8888, 0, 0, 0, 0);
    chk("R12 stable", out_data, held);
    chk("R12 no accept ptr", 64'(ptr_o), 64'h504);
    @(negedge clk); out_ready = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R12 queue drained", 64'(exp_q.size()), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule